// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block drives the memory reads for a single overlay window of a display pipeline. A frame is stored in memory as rows of pixels. The window shows a rectangle taken from that frame, so each screen line of the window reads one contiguous run of bytes. That run is the window width times the bytes per pixel. The generator then steps over the part of the stored row that lies outside the window and arrives at the start of the next row. Reads go out as word bursts. The nominal burst length follows the pixel depth. The last burst of a line is cut short so that it stays inside the line. Fetching for the frame stops once the read pointer reaches a programmed end address.

A frame-start pulse rewinds the read pointer to the programmed start address. Each line-start pulse releases one line's worth of bursts. Bursts are offered on a valid/ready interface: a burst counts as taken in the cycle where both `burst_valid` and `burst_ready` are high. While `burst_ready` is low, the offered burst holds its address and length. Apart from this handshake, all configuration and control pins are plain levels or single-cycle pulses. A separate combinational flag tells the pixel path whether the current raster position falls inside the window rectangle.

Top module: `ovl_fetch_agen`

## Requirements
- R1: During reset and after reset, until the first line is released, `burst_valid` is 0.
- R2: A `frame_start` pulse sets the read pointer to `cfg_start_addr` and drops any part of a line not yet fetched. From the next cycle, no burst is offered until a `line_start` pulse arrives.
- R3: A `line_start` pulse, taken while the window is enabled, no line is in progress and the pointer is below `cfg_end_addr`, releases exactly `cfg_line_bytes` bytes (a multiple of 4). These are issued as bursts at rising, back-to-back word addresses; each burst address is the previous one plus 4 times the previous `burst_words`.
- R4: The nominal burst length in words follows `cfg_depth`: code 0 (1 bit per pixel) gives 4; codes 1, 2 and 3 (2, 4 and 8 bits) give 8; codes 4, 5 and 6 (16, 24 and 32 bits) and the spare code 7 give 16.
- R5: Each burst has `burst_words` equal to the smaller of the nominal length and the words left in the line, so the last burst of a line is shortened.
- R6: When the last burst of a line is accepted, the pointer moves to the end of that line plus `cfg_skip_bytes`. The next line therefore starts `cfg_line_bytes + cfg_skip_bytes` after the previous line's start.
- R7: When the pointer is at or above `cfg_end_addr`, no burst is offered and `line_start` pulses are ignored.
- R8: While `burst_valid` is high and `burst_ready` is low, the burst stays offered with unchanged `burst_addr` and `burst_words` in the next cycle. This holds unless `frame_start` pulses or `cfg_enable` drops.
- R9: With `cfg_enable` low, `burst_valid` and `win_active` are 0 and `line_start` is ignored.
- R10: `win_active` is 1 exactly when enabled and `cfg_x0 <= ras_x <= cfg_x1` and `cfg_y0 <= ras_y <= cfg_y1`, with both corners included.
- R11: A `line_start` pulse that arrives while a line still has words left is ignored. The remaining bursts of that line continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Window enable |
| cfg_depth | input | 3 | Pixel depth code (see R4) |
| cfg_start_addr | input | 32 | Byte address of the window's first pixel |
| cfg_end_addr | input | 32 | Byte address at which fetching stops |
| cfg_line_bytes | input | 16 | Bytes fetched per line, multiple of 4 |
| cfg_skip_bytes | input | 16 | Bytes skipped after each line |
| cfg_x0 | input | 12 | Left column of the window |
| cfg_y0 | input | 12 | Top row of the window |
| cfg_x1 | input | 12 | Right column, inclusive |
| cfg_y1 | input | 12 | Bottom row, inclusive |
| ras_x | input | 12 | Current raster column |
| ras_y | input | 12 | Current raster row |
| frame_start | input | 1 | Single-cycle frame start pulse |
| line_start | input | 1 | Single-cycle line start pulse |
| burst_valid | output | 1 | Burst request offered |
| burst_ready | input | 1 | Burst request accepted this cycle |
| burst_addr | output | 32 | Byte address of the burst |
| burst_words | output | 5 | Burst length in words |
| win_active | output | 1 | Raster position lies inside the window |

## Verification
The case hardest to reach from the ports is a `line_start` pulse that arrives while a line is only partly fetched. The line-rate pulses normally arrive long after the bursts have drained. The stimulus reaches this case by accepting one burst and then holding `burst_ready` low across a fresh `line_start` pulse. It then checks that the rest of the line resumes at the right address and length and that no extra words are released. A second sequence walks a full frame of three lines. It checks each line's start against the skip arithmetic and checks that a fourth line pulse, which lands exactly on the end address, produces nothing.

// File: rtl/ovl_agen_pkg.sv
package ovl_agen_pkg;
  typedef enum logic [2:0] {
    PD_1B  = 3'd0,
    PD_2B  = 3'd1,
    PD_4B  = 3'd2,
    PD_8B  = 3'd3,
    PD_16B = 3'd4,
    PD_24B = 3'd5,
    PD_32B = 3'd6,
    PD_SPR = 3'd7
  } pix_depth_e;

  localparam int unsigned SHORT_BURST = 4;
  localparam int unsigned MID_BURST   = 8;
  localparam int unsigned LONG_BURST  = 16;
endpackage

// File: rtl/ovl_burst_len.sv
module ovl_burst_len
  import ovl_agen_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic [2:0]       depth,
  output logic [LEN_W-1:0] nom_words
);
  pix_depth_e code;
  assign code = pix_depth_e'(depth);

  always_comb begin
    unique case (code)
      PD_1B:               nom_words = LEN_W'(SHORT_BURST);
      PD_2B, PD_4B, PD_8B: nom_words = LEN_W'(MID_BURST);
      default:             nom_words = LEN_W'(LONG_BURST);
    endcase
  end
endmodule

// File: rtl/ovl_win_hit.sv
module ovl_win_hit #(
  parameter int unsigned COORD_W = 12
) (
  input  logic               enable,
  input  logic [COORD_W-1:0] pos_x,
  input  logic [COORD_W-1:0] pos_y,
  input  logic [COORD_W-1:0] tl_x,
  input  logic [COORD_W-1:0] tl_y,
  input  logic [COORD_W-1:0] br_x,
  input  logic [COORD_W-1:0] br_y,
  output logic               hit
);
  logic in_cols, in_rows;
  assign in_cols = (pos_x >= tl_x) && (pos_x <= br_x);
  assign in_rows = (pos_y >= tl_y) && (pos_y <= br_y);
  assign hit     = enable && in_cols && in_rows;
endmodule

// File: rtl/ovl_line_walker.sv
module ovl_line_walker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_W     = 16,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [LINE_W-1:0] line_bytes,
  input  logic [LINE_W-1:0] skip_bytes,
  input  logic [LEN_W-1:0]  nom_words,
  output logic              burst_valid,
  input  logic              burst_ready,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LEN_W-1:0]  burst_words
);
  localparam int unsigned SH = $clog2(WORD_BYTES);

  logic [ADDR_W-1:0] cur_addr;
  logic [LINE_W-1:0] left_w;
  logic [LINE_W-1:0] nom_ext, take_w;
  logic [ADDR_W-1:0] step, next_addr;
  logic              busy, in_range, last, accept;

  assign busy      = (left_w != '0);
  assign in_range  = (cur_addr < end_addr);
  assign nom_ext   = LINE_W'(nom_words);
  assign take_w    = (left_w < nom_ext) ? left_w : nom_ext;
  assign last      = (left_w == take_w);
  assign step      = ADDR_W'(take_w) << SH;
  assign next_addr = cur_addr + step + (last ? ADDR_W'(skip_bytes) : '0);

  assign burst_valid = enable && busy && in_range;
  assign burst_addr  = cur_addr;
  assign burst_words = LEN_W'(take_w);
  assign accept      = burst_valid && burst_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left_w   <= '0;
    end else if (frame_start) begin
      cur_addr <= start_addr;
      left_w   <= '0;
    end else if (accept) begin
      cur_addr <= next_addr;
      left_w   <= left_w - take_w;
    end else if (line_start && enable && !busy && in_range) begin
      left_w <= line_bytes >> SH;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready && !frame_start) |=>
      (!enable || (burst_valid && $stable(burst_addr) && $stable(burst_words)))); // R8

  AST_FRAME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !burst_valid); // R2

  AST_WORDS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_words != '0) && (burst_words <= nom_words)); // R5

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !burst_valid); // R1
endmodule

// File: rtl/ovl_fetch_agen.sv
module ovl_fetch_agen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_W     = 16,
  parameter int unsigned COORD_W    = 12,
  parameter int unsigned LEN_W      = 5,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic [2:0]         cfg_depth,
  input  logic [ADDR_W-1:0]  cfg_start_addr,
  input  logic [ADDR_W-1:0]  cfg_end_addr,
  input  logic [LINE_W-1:0]  cfg_line_bytes,
  input  logic [LINE_W-1:0]  cfg_skip_bytes,
  input  logic [COORD_W-1:0] cfg_x0,
  input  logic [COORD_W-1:0] cfg_y0,
  input  logic [COORD_W-1:0] cfg_x1,
  input  logic [COORD_W-1:0] cfg_y1,
  input  logic [COORD_W-1:0] ras_x,
  input  logic [COORD_W-1:0] ras_y,
  input  logic               frame_start,
  input  logic               line_start,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic [ADDR_W-1:0]  burst_addr,
  output logic [LEN_W-1:0]   burst_words,
  output logic               win_active
);
  logic [LEN_W-1:0] nom_words;

  ovl_burst_len #(.LEN_W(LEN_W)) u_len (
    .depth     (cfg_depth),
    .nom_words (nom_words)
  );

  ovl_line_walker #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .LEN_W(LEN_W), .WORD_BYTES(WORD_BYTES)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .frame_start (frame_start),
    .line_start  (line_start),
    .start_addr  (cfg_start_addr),
    .end_addr    (cfg_end_addr),
    .line_bytes  (cfg_line_bytes),
    .skip_bytes  (cfg_skip_bytes),
    .nom_words   (nom_words),
    .burst_valid (burst_valid),
    .burst_ready (burst_ready),
    .burst_addr  (burst_addr),
    .burst_words (burst_words)
  );

  ovl_win_hit #(.COORD_W(COORD_W)) u_hit (
    .enable (cfg_enable),
    .pos_x  (ras_x),
    .pos_y  (ras_y),
    .tl_x   (cfg_x0),
    .tl_y   (cfg_y0),
    .br_x   (cfg_x1),
    .br_y   (cfg_y1),
    .hit    (win_active)
  );

  AST_ACTIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active || burst_valid) |-> cfg_enable); // R9
endmodule

// File: tb/ovl_fetch_agen_tb_top.sv
module ovl_fetch_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [2:0]  cfg_depth = 3'd6;
  logic [31:0] cfg_start_addr = '0, cfg_end_addr = '0;
  logic [15:0] cfg_line_bytes = '0, cfg_skip_bytes = '0;
  logic [11:0] cfg_x0 = '0, cfg_y0 = '0, cfg_x1 = '0, cfg_y1 = '0;
  logic [11:0] ras_x = '0, ras_y = '0;
  logic        frame_start = 1'b0, line_start = 1'b0, burst_ready = 1'b0;
  logic        burst_valid, win_active;
  logic [31:0] burst_addr;
  logic [4:0]  burst_words;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ovl_fetch_agen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_depth(cfg_depth),
    .cfg_start_addr(cfg_start_addr), .cfg_end_addr(cfg_end_addr),
    .cfg_line_bytes(cfg_line_bytes), .cfg_skip_bytes(cfg_skip_bytes),
    .cfg_x0(cfg_x0), .cfg_y0(cfg_y0), .cfg_x1(cfg_x1), .cfg_y1(cfg_y1),
    .ras_x(ras_x), .ras_y(ras_y), .frame_start(frame_start),
    .line_start(line_start), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_words(burst_words), .win_active(win_active)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    #1 chk("R2 quiet after frame start", burst_valid, 0);
  endtask

  task automatic pulse_line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  task automatic run_line(input logic [31:0] a0, input int words, input int nom, input string req);
    logic [31:0] a = a0;
    int left = words;
    while (left > 0) begin
      int e = (left < nom) ? left : nom;
      #1;
      chk({req, " valid"}, burst_valid, 1);
      chk({req, " addr"},  burst_addr, a);
      chk({req, " R5 len"}, burst_words, e);
      burst_ready = 1'b1;
      @(negedge clk) burst_ready = 1'b0;
      a = a + 32'(e * 4);
      left = left - e;
    end
    #1 chk({req, " R3 line drained"}, burst_valid, 0);
  endtask

  task automatic t_reset();
    #1 chk("R1 reset valid", burst_valid, 0);
    chk("R1 reset active", win_active, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk) #1 chk("R1 idle after reset", burst_valid, 0);
  endtask

  task automatic t_frame_walk();
    cfg_enable = 1'b1; cfg_depth = 3'd6;
    cfg_start_addr = 32'h1000; cfg_line_bytes = 16'd160; cfg_skip_bytes = 16'd64;
    cfg_end_addr = 32'h1000 + 32'd672;
    pulse_frame();
    for (int ln = 0; ln < 3; ln++) begin
      pulse_line();
      run_line(32'h1000 + 32'(ln * 224), 40, 16, "R6 line start");
    end
    pulse_line();
    #1 chk("R7 end address stops fetch", burst_valid, 0);
  endtask

  task automatic t_depths();
    cfg_start_addr = 32'h2000; cfg_end_addr = 32'h10000; cfg_line_bytes = 16'd256;
    for (int d = 0; d < 8; d++) begin
      int e = (d == 0) ? 4 : (d <= 3) ? 8 : 16;
      cfg_depth = 3'(d);
      pulse_frame();
      pulse_line();
      #1 chk("R4 depth burst valid", burst_valid, 1);
      chk("R4 depth burst length", burst_words, e);
      chk("R2 reload address", burst_addr, 32'h2000);
    end
  endtask

  task automatic t_backpressure();
    cfg_depth = 3'd4; cfg_start_addr = 32'h4000; cfg_end_addr = 32'h8000;
    cfg_line_bytes = 16'd96;
    pulse_frame();
    pulse_line();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) #1;
      chk("R8 held valid", burst_valid, 1);
      chk("R8 held addr", burst_addr, 32'h4000);
      chk("R8 held len", burst_words, 16);
    end
    run_line(32'h4000, 24, 16, "R8 after stall");
  endtask

  task automatic t_midline_pulse();
    cfg_depth = 3'd3; cfg_start_addr = 32'h5000; cfg_line_bytes = 16'd80;
    pulse_frame();
    pulse_line();
    #1 chk("R11 first addr", burst_addr, 32'h5000);
    chk("R11 first len", burst_words, 8);
    burst_ready = 1'b1;
    @(negedge clk) burst_ready = 1'b0;
    pulse_line();
    run_line(32'h5020, 12, 8, "R11 rest of line");
  endtask

  task automatic t_disable();
    cfg_x0 = 12'd10; cfg_y0 = 12'd5; cfg_x1 = 12'd19; cfg_y1 = 12'd8;
    ras_x = 12'd12; ras_y = 12'd6;
    cfg_enable = 1'b0;
    cfg_start_addr = 32'h6000;
    pulse_frame();
    pulse_line();
    #1 chk("R9 disabled no burst", burst_valid, 0);
    chk("R9 disabled not active", win_active, 0);
    cfg_enable = 1'b1;
    #1 chk("R9 line pulse was ignored", burst_valid, 0);
  endtask

  task automatic t_window();
    cfg_enable = 1'b1;
    ras_x = 12'd10; ras_y = 12'd5; #1 chk("R10 top-left in", win_active, 1);
    ras_x = 12'd19; ras_y = 12'd8; #1 chk("R10 bottom-right in", win_active, 1);
    ras_x = 12'd9;  ras_y = 12'd5; #1 chk("R10 left out", win_active, 0);
    ras_x = 12'd20; ras_y = 12'd8; #1 chk("R10 right out", win_active, 0);
    ras_x = 12'd10; ras_y = 12'd4; #1 chk("R10 above out", win_active, 0);
    ras_x = 12'd10; ras_y = 12'd9; #1 chk("R10 below out", win_active, 0);
  endtask

  initial begin
    t_reset();
    t_frame_walk();
    t_depths();
    t_backpressure();
    t_midline_pulse();
    t_disable();
    t_window();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule